// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block produces the raster timing for a digital display output. Software programs the line and frame lengths, the horizontal and vertical active windows, the sync pulse widths, the sync polarities and an optional interlaced second field through a narrow write port. The block then counts pixels and lines on the pixel clock and drives horizontal sync, vertical sync, a data-enable strobe and the current pixel column and line number to the pixel pipeline downstream.

Every write is checked against the fields of its target register. A value that sets a bit outside the legal fields, or a write to an address with no register, is dropped and flagged. Accepted values go to a staging copy. The generator copies that staging copy into its working set only at a frame boundary, or while it is stopped, so a frame already on screen always runs under one consistent configuration.

A typical use programs the registers with the generator stopped and then sets the run bit. Later changes, such as a new sync width or polarity, are written while the generator runs and appear from the next frame onward.

Top module: `vid_timing_gen`

## Requirements
- R1: Register map, with every field POS_W (13) bits wide. Address 0 holds the last line number (bits 28:16) and the last pixel number (bits 12:0); each is the total count minus one. Address 1 holds the horizontal active stop (28:16) and start (12:0). Address 2 holds the vertical active stop (28:16) and start (12:0). Address 3 holds the vsync width (28:16) and hsync width (12:0). Address 4 holds the field-2 last line number (12:0). Address 5 holds the field-2 vertical stop (28:16) and start (12:0). Address 6 is control: bit 31 interlace, bit 29 hsync active-low, bit 28 vsync active-low, bit 0 run. Address 7 is unmapped.
- R2: While running, x counts from 0 to the last pixel number and then returns to 0. y advances by one at each line end and returns to 0 after the field's last line.
- R3: The internal hsync level is high when x is below the hsync width, and the internal vsync level is high when y is below the vsync width. Each output is that level inverted when its active-low control bit is set.
- R4: de is high only when start ≤ x < stop horizontally and start < y ≤ stop vertically, using the window of the current field.
- R5: With interlace set, each frame is field 1 (lines 0 to the address-0 last line, address-2 window) followed by field 2 (lines 0 to the address-4 last line, address-5 window). With interlace clear, every frame is a single field-1 pass.
- R6: A write that sets any bit outside the fields of R1, or that targets address 7, changes nothing, and wr_err is 1 in the cycle after it. An accepted write leaves wr_err at 0.
- R7: Values written while running take effect from pixel (0,0) of the next frame. The frame in progress finishes under the old values.
- R8: After a write that clears run, within two cycles x and y are 0, de is low, and both syncs sit at their inactive level. After a write that sets run, pixel (0,0) appears in the second cycle after the write edge.
- R9: After reset, x, y, de, hsync, vsync and wr_err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| wr_err | output | 1 | Previous write was rejected |
| hsync | output | 1 | Horizontal sync, polarity per control |
| vsync | output | 1 | Vertical sync, polarity per control |
| de | output | 1 | Active-video strobe |
| x | output | 13 | Current pixel column |
| y | output | 13 | Current line within the field |

## Verification
The assertions assume a consistent configuration: active starts below stops, stops no larger than the line or field length, and sync widths inside the totals. They also assume at most one write per cycle, and that control writes made while running keep the run bit set unless the intent is to stop. The stimulus uses small consistent modes, with frames of 17 pixels by 9 or 10 lines, so whole frames can be compared pixel by pixel. The full-size 720p values are only written, to exercise range checking. Live changes are made in the middle of a frame, so the boundary behaviour of the shadow copy is observed at the outputs.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

   localparam int unsigned FIELD_W = 16;

   typedef enum logic [2:0] {
      A_TOTAL = 3'd0,
      A_HWIN  = 3'd1,
      A_VWIN  = 3'd2,
      A_SYNC  = 3'd3,
      A_F2TOT = 3'd4,
      A_F2WIN = 3'd5,
      A_CTRL  = 3'd6,
      A_NONE  = 3'd7
   } vtg_addr_e;

   localparam logic [31:0] CTRL_MASK = 32'hB000_0001;

   typedef struct packed {
      logic [FIELD_W-1:0] ht;
      logic [FIELD_W-1:0] vt;
      logic [FIELD_W-1:0] h_start;
      logic [FIELD_W-1:0] h_stop;
      logic [FIELD_W-1:0] v_start;
      logic [FIELD_W-1:0] v_stop;
      logic [FIELD_W-1:0] hsw;
      logic [FIELD_W-1:0] vsw;
      logic [FIELD_W-1:0] vt2;
      logic [FIELD_W-1:0] v2_start;
      logic [FIELD_W-1:0] v2_stop;
      logic               il;
      logic               hs_low;
      logic               vs_low;
   } vtg_cfg_t;

   function automatic logic [31:0] legal_bits(input vtg_addr_e a, input int unsigned pw);
      logic [31:0] lo;
      lo = (32'd1 << pw) - 32'd1;
      case (a)
         A_TOTAL, A_HWIN, A_VWIN, A_SYNC, A_F2WIN: return lo | (lo << 16);
         A_F2TOT:                                  return lo;
         A_CTRL:                                   return CTRL_MASK;
         default:                                  return 32'd0;
      endcase
   endfunction

endpackage

// File: rtl/vtg_cfg_regs.sv
module vtg_cfg_regs
   import vtg_pkg::*;
#(
   parameter int unsigned POS_W = 13,
   parameter bit          F2_EN = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [2:0]  wr_addr,
   input  logic [31:0] wr_data,
   input  logic        frame_end,
   output logic        wr_err,
   output logic        run,
   output vtg_cfg_t    act
);

   vtg_cfg_t    stg;
   logic        stg_run;
   vtg_addr_e   addr;
   logic [31:0] mask;
   logic        f2_ok;
   logic        bad;

   generate
      if (POS_W < 2 || POS_W > FIELD_W) begin : g_bad_width
         $error("vtg_cfg_regs: POS_W out of range");
      end
      if (F2_EN) begin : g_f2_map
         assign f2_ok = 1'b1;
      end else begin : g_f2_unmap
         assign f2_ok = (addr != A_F2TOT) && (addr != A_F2WIN);
      end
   endgenerate

   assign addr = vtg_addr_e'(wr_addr);
   assign mask = legal_bits(addr, POS_W);
   assign bad  = !f2_ok || (mask == 32'd0) || ((wr_data & ~mask) != 32'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg     <= '0;
         stg_run <= 1'b0;
         wr_err  <= 1'b0;
      end else begin
         wr_err <= wr_en && bad;
         if (wr_en && !bad) begin
            case (addr)
               A_TOTAL: begin stg.vt <= wr_data[31:16]; stg.ht <= wr_data[15:0]; end
               A_HWIN:  begin stg.h_stop <= wr_data[31:16]; stg.h_start <= wr_data[15:0]; end
               A_VWIN:  begin stg.v_stop <= wr_data[31:16]; stg.v_start <= wr_data[15:0]; end
               A_SYNC:  begin stg.vsw <= wr_data[31:16]; stg.hsw <= wr_data[15:0]; end
               A_F2TOT: stg.vt2 <= wr_data[15:0];
               A_F2WIN: begin stg.v2_stop <= wr_data[31:16]; stg.v2_start <= wr_data[15:0]; end
               A_CTRL:  begin
                  stg.il     <= wr_data[31];
                  stg.hs_low <= wr_data[29];
                  stg.vs_low <= wr_data[28];
                  stg_run    <= wr_data[0];
               end
               default: ;
            endcase
         end
      end
   end

   // working copy: follows staging while stopped, otherwise only at frame end
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act <= '0;
         run <= 1'b0;
      end else begin
         run <= stg_run;
         if (!run || frame_end) act <= stg;
      end
   end

   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !frame_end) |=> $stable(act)); // R7

   AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> ($stable(stg) && $stable(stg_run))); // R6

endmodule

// File: rtl/vtg_scan_counters.sv
module vtg_scan_counters
   import vtg_pkg::*;
#(
   parameter int unsigned POS_W = 13,
   parameter bit          F2_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic [FIELD_W-1:0] ht,
   input  logic [FIELD_W-1:0] vt,
   input  logic [FIELD_W-1:0] vt2,
   input  logic               il,
   output logic [POS_W-1:0]   x,
   output logic [POS_W-1:0]   y,
   output logic               field,
   output logic               frame_end
);

   logic               il_eff;
   logic [FIELD_W-1:0] cur_vt;
   logic               line_end;
   logic               fld_end;

   generate
      if (F2_EN) begin : g_il
         assign il_eff = il;
      end else begin : g_no_il
         assign il_eff = 1'b0;
      end
   endgenerate

   assign cur_vt    = field ? vt2 : vt;
   assign line_end  = (FIELD_W'(x) == ht);
   assign fld_end   = line_end && (FIELD_W'(y) == cur_vt);
   assign frame_end = run && fld_end && (field || !il_eff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x     <= '0;
         y     <= '0;
         field <= 1'b0;
      end else if (!run) begin
         x     <= '0;
         y     <= '0;
         field <= 1'b0;
      end else if (line_end) begin
         x <= '0;
         if (fld_end) begin
            y     <= '0;
            field <= il_eff && !field;
         end else begin
            y <= y + POS_W'(1);
         end
      end else begin
         x <= x + POS_W'(1);
      end
   end

   AST_X_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (FIELD_W'(x) <= ht)); // R2

   AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !line_end) |=> (x == $past(x) + POS_W'(1))); // R2

   AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (x == '0 && y == '0 && !field)); // R8

endmodule

// File: rtl/vtg_sync_decode.sv
module vtg_sync_decode
   import vtg_pkg::*;
#(
   parameter int unsigned POS_W = 13
) (
   input  logic               run,
   input  logic [POS_W-1:0]   x,
   input  logic [POS_W-1:0]   y,
   input  logic               field,
   input  logic [FIELD_W-1:0] h_start,
   input  logic [FIELD_W-1:0] h_stop,
   input  logic [FIELD_W-1:0] v_start,
   input  logic [FIELD_W-1:0] v_stop,
   input  logic [FIELD_W-1:0] v2_start,
   input  logic [FIELD_W-1:0] v2_stop,
   input  logic [FIELD_W-1:0] hsw,
   input  logic [FIELD_W-1:0] vsw,
   input  logic               hs_low,
   input  logic               vs_low,
   output logic               hsync,
   output logic               vsync,
   output logic               de
);

   logic [FIELD_W-1:0] xe, ye, vb, ve;
   logic               h_in, v_in;

   assign xe   = FIELD_W'(x);
   assign ye   = FIELD_W'(y);
   assign vb   = field ? v2_start : v_start;
   assign ve   = field ? v2_stop  : v_stop;
   assign h_in = (xe >= h_start) && (xe < h_stop);
   assign v_in = (ye > vb) && (ye <= ve);

   assign de    = run && h_in && v_in;
   assign hsync = (run && (xe < hsw)) ^ hs_low;
   assign vsync = (run && (ye < vsw)) ^ vs_low;

endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
   import vtg_pkg::*;
#(
   parameter int unsigned POS_W = 13,
   parameter bit          F2_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [31:0]      wr_data,
   output logic             wr_err,
   output logic             hsync,
   output logic             vsync,
   output logic             de,
   output logic [POS_W-1:0] x,
   output logic [POS_W-1:0] y
);

   vtg_cfg_t act;
   logic     run;
   logic     field;
   logic     frame_end;

   vtg_cfg_regs #(.POS_W(POS_W), .F2_EN(F2_EN)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .frame_end (frame_end),
      .wr_err    (wr_err),
      .run       (run),
      .act       (act)
   );

   vtg_scan_counters #(.POS_W(POS_W), .F2_EN(F2_EN)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .ht        (act.ht),
      .vt        (act.vt),
      .vt2       (act.vt2),
      .il        (act.il),
      .x         (x),
      .y         (y),
      .field     (field),
      .frame_end (frame_end)
   );

   vtg_sync_decode #(.POS_W(POS_W)) u_dec (
      .run      (run),
      .x        (x),
      .y        (y),
      .field    (field),
      .h_start  (act.h_start),
      .h_stop   (act.h_stop),
      .v_start  (act.v_start),
      .v_stop   (act.v_stop),
      .v2_start (act.v2_start),
      .v2_stop  (act.v2_stop),
      .hsw      (act.hsw),
      .vsw      (act.vsw),
      .hs_low   (act.hs_low),
      .vs_low   (act.vs_low),
      .hsync    (hsync),
      .vsync    (vsync),
      .de       (de)
   );

   AST_FIELD_IL: assert property (@(posedge clk) disable iff (!rst_n)
      field |-> act.il); // R5

endmodule

// File: tb/vid_timing_gen_test.sv
`timescale 1ns/1ps
module vid_timing_gen_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        wr_err, hsync, vsync, de;
   logic [12:0] x, y;

   always #4 clk = ~clk;

   vid_timing_gen uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_err(wr_err), .hsync(hsync), .vsync(vsync), .de(de), .x(x), .y(y)
   );

   typedef struct { int x; int y; bit hs; bit vs; bit de; } exp_t;
   exp_t  exp_q[$];
   exp_t  cur;
   bit    mon_on = 1'b0;
   string phase = "";
   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;

   // mode used to build expectations
   int m_ht, m_vt, m_hb, m_he, m_vb, m_ve, m_hw, m_vw, m_vt2, m_vb2, m_ve2;
   bit m_il, m_hn, m_vn;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d, output logic e);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      e = wr_err;
   endtask

   // driver side of the scoreboard: one expected item per pixel clock
   task automatic push_frame();
      for (int f = 0; f < (m_il ? 2 : 1); f++) begin
         int lv = (f == 0) ? m_vt : m_vt2;
         for (int yy = 0; yy <= lv; yy++) begin
            for (int xx = 0; xx <= m_ht; xx++) begin
               exp_t it;
               bit vin;
               vin   = (f == 0) ? (yy > m_vb && yy <= m_ve) : (yy > m_vb2 && yy <= m_ve2);
               it.x  = xx;
               it.y  = yy;
               it.hs = (xx < m_hw) ^ m_hn;
               it.vs = (yy < m_vw) ^ m_vn;
               it.de = (xx >= m_hb) && (xx < m_he) && vin;
               exp_q.push_back(it);
            end
         end
      end
   endtask

   // monitor side: pop and compare each cycle
   always @(negedge clk) begin
      if (mon_on && exp_q.size() > 0) begin
         cur = exp_q.pop_front();
         chk((int'(x) == cur.x) && (int'(y) == cur.y), "R2", {phase, " x*10000+y"},
             int'(x) * 10000 + int'(y), cur.x * 10000 + cur.y);
         chk((hsync == cur.hs) && (vsync == cur.vs), "R3", {phase, " hs*2+vs"},
             int'({hsync, vsync}), int'({cur.hs, cur.vs}));
         chk(de == cur.de, "R4", {phase, " de"}, int'(de), int'(cur.de));
      end
   end

   task automatic run_queue();
      @(posedge clk);
      mon_on = 1'b1;
      while (exp_q.size() > 0) @(negedge clk);
      mon_on = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
   end

   initial begin
      logic e;
      int ht720, vt720;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk(x == 0 && y == 0, "R9", "x,y after reset", int'(x) + int'(y), 0);
      chk(!de && !hsync && !vsync, "R9", "de/hs/vs after reset", int'({de, hsync, vsync}), 0);
      chk(!wr_err, "R9", "wr_err after reset", int'(wr_err), 0);

      // R1 / R6: 720p values fit the fields and are accepted
      ht720 = 1280 + 110 + 40 + 220 - 1;
      vt720 = 720 + 5 + 5 + 20 - 1;
      wr(3'd0, (32'(vt720) << 16) | 32'(ht720), e);
      chk(!e, "R6", "720p totals accepted", int'(e), 0);
      wr(3'd1, (32'(ht720 + 1 - 110) << 16) | 32'(220 + 40), e);
      chk(!e, "R6", "720p hwin accepted", int'(e), 0);
      wr(3'd2, (32'(vt720 - 5) << 16) | 32'(20 + 5 - 1), e);
      chk(!e, "R1", "720p vwin accepted", int'(e), 0);

      // R6 rejections
      wr(3'd0, 32'h0000_2000, e);
      chk(e, "R6", "bit 13 rejected", int'(e), 1);
      wr(3'd7, 32'h0, e);
      chk(e, "R6", "unmapped address rejected", int'(e), 1);
      wr(3'd6, 32'h4000_0001, e);
      chk(e, "R6", "control bit 30 rejected", int'(e), 1);
      @(negedge clk);
      chk(!wr_err && x == 0 && !de, "R6", "rejected run write kept block stopped",
          int'({wr_err, de}) + int'(x), 0);

      // small mode A: 17 pixels x 9 lines
      wr(3'd0, (32'd8 << 16) | 32'd16, e);
      wr(3'd1, (32'd15 << 16) | 32'd7, e);
      wr(3'd2, (32'd7 << 16) | 32'd3, e);
      wr(3'd3, (32'd2 << 16) | 32'd3, e);
      // R6: rejected write must not alter totals; the frame below proves it
      wr(3'd0, 32'h2000_0004, e);
      chk(e, "R6", "bit 29 in totals rejected", int'(e), 1);

      m_ht = 16; m_vt = 8; m_hb = 7; m_he = 15; m_vb = 3; m_ve = 7;
      m_hw = 3; m_vw = 2; m_vt2 = 0; m_vb2 = 0; m_ve2 = 0;
      m_il = 0; m_hn = 0; m_vn = 0;
      phase = "R1 R8 R6 frame A";
      push_frame();
      // R7: second frame uses the values written mid-frame
      m_hw = 5; m_hn = 1;
      push_frame();
      wr(3'd6, 32'h0000_0001, e);   // R8 start
      fork
         run_queue();
         begin
            repeat (40) @(negedge clk);
            phase = "R7 shadow";
            wr(3'd3, (32'd2 << 16) | 32'd5, e);
            wr(3'd6, 32'h2000_0001, e);
         end
      join

      // R8 stop with active-low syncs selected
      wr(3'd6, 32'h3000_0000, e);
      repeat (2) @(negedge clk);
      chk(x == 0 && y == 0, "R8", "x,y held at zero", int'(x) + int'(y), 0);
      chk(!de, "R8", "de low when stopped", int'(de), 0);
      chk(hsync && vsync, "R8", "syncs inactive high", int'({hsync, vsync}), 3);
      repeat (5) @(negedge clk);
      chk(x == 0 && y == 0 && !de, "R8", "still held", int'(x) + int'(y) + int'(de), 0);

      // R5 interlaced frame
      wr(3'd4, 32'd9, e);
      chk(!e, "R5", "field2 total accepted", int'(e), 0);
      wr(3'd5, (32'd8 << 16) | 32'd4, e);
      wr(3'd3, (32'd2 << 16) | 32'd3, e);
      m_hw = 3; m_hn = 0; m_vn = 0; m_il = 1;
      m_vt2 = 9; m_vb2 = 4; m_ve2 = 8;
      phase = "R5 interlace";
      push_frame();
      wr(3'd6, 32'h8000_0001, e);
      run_queue();
      wr(3'd6, 32'h0, e);
      repeat (3) @(negedge clk);
      chk(x == 0 && y == 0 && !hsync && !vsync && !de, "R8", "stopped, active-high idle",
          int'(x) + int'(y) + int'({hsync, vsync, de}), 0);
      summary();
   end

endmodule